// File: doc/BRIEF.md
# Scanline Timing and Blanking Generator

This block paces every scanline of a tile-based video display processor from the system master clock. It counts master cycles across a fixed-length line and keeps a readable horizontal position counter and a vertical line counter. At the line boundary it opens horizontal blanking, steps the line counter and raises a horizontal interrupt request, all on the same cycle. It closes blanking when active display resumes.

The block also decides when register writes reach the picture. A bank of per-line settings is copied from the write-side registers once per line, a fixed delay after blanking opens, so later writes only affect the next line. The display-enable bit and the border colour bypass that copy and act at once. A second strobe marks the point where the processor would begin its interrupt handler. The processor, rendering and memory fetching sit outside this block.

Top module: `scanline_timer`

## Requirements
- R1: A line lasts LINE_CYCLES master cycles (default 3416). The cycle count runs from 0 to LINE_CYCLES-1 and then starts again.
- R2: On the clock edge that ends a line, the blanking flag goes high, the line counter steps by one and the interrupt request goes high. All three become visible together in cycle 0 of the new line.
- R3: At a line boundary, hcount reloads to 0x85 when wide_mode is 0 (32-cell) or to 0xA5 when it is 1 (40-cell). wide_mode is sampled only on that edge, and changes during a line have no effect until the next boundary.
- R4: Within a line, hcount rises by one every 8 master cycles (start value plus cycle/8, modulo 256). In the first line after reset it counts from 0.
- R5: Blanking clears when the cycle count reaches the active-display start of the current line's mode (default 2560 for both modes).
- R6: status is 16 bits. Bit 2 is the blanking flag, bit 7 is the pending interrupt request, and every other bit is 0.
- R7: cap_stb is high for one cycle at cycle 252 of every line. In that cycle line_regs holds a copy of all write-side registers, and it does not change at any other time. Register n occupies line_regs[8n+7:8n].
- R8: A write to register 1 sets disp_en from data bit 6, and a write to register 7 sets border. Both become visible in the cycle after the write, at any point in the line.
- R9: ack_stb is high for one cycle at cycle 308 of every line, 56 cycles after cap_stb, and the two are never high together.
- R10: hint_req stays high until an int_ack pulse clears it on the next edge. A line boundary that finds it already pending leaves it high.
- R11: The line counter wraps from LINES-1 to 0 (default 262 lines).
- R12: While rst_n is low, every counter and flag is 0. After release, the first line runs from cycle 0 with blanking low and hcount and vcount at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 selects 40-cell mode, 0 selects 32-cell mode; sampled at line start |
| int_ack | input | 1 | One-cycle pulse that clears the interrupt request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register number |
| wr_data | input | 8 | Register write data |
| hblank | output | 1 | Horizontal blanking flag |
| hint_req | output | 1 | Horizontal interrupt request |
| hcount | output | 8 | Horizontal position counter |
| vcount | output | 9 | Line counter |
| status | output | 16 | Status word |
| cap_stb | output | 1 | Per-line register capture strobe |
| ack_stb | output | 1 | Interrupt-handler start strobe |
| disp_en | output | 1 | Display enable, applied immediately |
| border | output | 8 | Border colour, applied immediately |
| line_regs | output | 128 | Per-line copy of the 16 registers |

## Verification
The hardest case to reach is the separation between the two paths into a register: a write made after the capture point must stay out of line_regs for the rest of that line and appear exactly at the next capture, while disp_en and border change in the very next cycle. The bench counts master cycles from reset release and places writes at known cycle offsets inside a line, before and after cycle 252. It then samples line_regs at cycle 252 of that line and of the next line. The bench instance sets the frame to four lines so that the line-counter wrap, and a mode change taking effect only at a line boundary, can be reached in a short run.

// File: rtl/scanline_pkg.sv
package scanline_pkg;
  localparam logic [7:0] HC_START_NARROW = 8'h85;
  localparam logic [7:0] HC_START_WIDE   = 8'hA5;
  localparam int STAT_BLANK_BIT = 2;
  localparam int STAT_HINT_BIT  = 7;
  localparam int CPU_DIV        = 7;
  localparam int CAP_CPU_CYC    = 36;
  localparam int ACK_CPU_CYC    = 44;

  function automatic logic [7:0] hc_start(input logic wide);
    return wide ? HC_START_WIDE : HC_START_NARROW;
  endfunction
endpackage

// File: rtl/line_cycle_ctr.sv
module line_cycle_ctr #(
  parameter int LINE_CYCLES = 3416,
  parameter int CW = $clog2(LINE_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cyc,
  output logic          line_end
);
  localparam logic [CW-1:0] LAST = CW'(LINE_CYCLES - 1);

  logic [CW-1:0] cyc_q, cyc_d;

  assign line_end = (cyc_q == LAST);
  assign cyc      = cyc_q;

  always_comb begin
    cyc_d = line_end ? '0 : cyc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_d;
  end

  // R1
  cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= LAST);

  // R1
  cyc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (cyc_q == '0));
endmodule

// File: rtl/hv_counter.sv
module hv_counter
  import scanline_pkg::*;
#(
  parameter int CW = 12,
  parameter int LINES = 262,
  parameter int VW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cyc,
  input  logic          line_end,
  input  logic          wide_in,
  output logic [7:0]    hcount,
  output logic [VW-1:0] vcount,
  output logic          wide_q
);
  localparam logic [VW-1:0] LAST_LINE = VW'(LINES - 1);

  logic [7:0]    hc_q, hc_d;
  logic [VW-1:0] vc_q, vc_d;
  logic          wide_d, wq;
  logic          tick8;

  assign tick8 = (cyc[2:0] == 3'b111);

  always_comb begin
    hc_d   = hc_q;
    vc_d   = vc_q;
    wide_d = wq;
    if (line_end) begin
      hc_d   = hc_start(wide_in);
      wide_d = wide_in;
      vc_d   = (vc_q == LAST_LINE) ? '0 : vc_q + 1'b1;
    end else if (tick8) begin
      hc_d = hc_q + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q <= '0;
      vc_q <= '0;
      wq   <= 1'b0;
    end else begin
      hc_q <= hc_d;
      vc_q <= vc_d;
      wq   <= wide_d;
    end
  end

  assign hcount = hc_q;
  assign vcount = vc_q;
  assign wide_q = wq;

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(line_end) |-> $stable(wq));

  // R11
  vcount_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vc_q) |-> $past(line_end));

  // R11
  vcount_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vc_q <= LAST_LINE);

  // R4
  hcount_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(line_end) && ($past(cyc[2:0]) != 3'b111)) |-> $stable(hc_q));
endmodule

// File: rtl/line_reg_bank.sv
module line_reg_bank #(
  parameter int NREG = 16,
  parameter int DW = 8,
  parameter int AW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             capture,
  output logic [NREG*DW-1:0] live_flat,
  output logic [NREG*DW-1:0] line_flat
);
  logic [DW-1:0] live_q [NREG];
  logic [DW-1:0] live_d [NREG];
  logic [DW-1:0] line_q [NREG];
  logic [DW-1:0] line_d [NREG];

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      live_d[i] = live_q[i];
      line_d[i] = capture ? live_q[i] : line_q[i];
    end
    if (wr_en) live_d[wr_addr] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        live_q[i] <= '0;
        line_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        live_q[i] <= live_d[i];
        line_q[i] <= line_d[i];
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign live_flat[g*DW +: DW] = live_q[g];
    assign line_flat[g*DW +: DW] = line_q[g];
  end

  // R7
  line_copy_only_at_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_flat) |-> $past(capture));
endmodule

// File: rtl/scanline_timer.sv
module scanline_timer
  import scanline_pkg::*;
#(
  parameter int LINE_CYCLES = 3416,
  parameter int LINES = 262,
  parameter int ACT_START_NARROW = 2560,
  parameter int ACT_START_WIDE = 2560,
  parameter int NREG = 16,
  parameter int CTRL_REG = 1,
  parameter int DISP_BIT = 6,
  parameter int BORDER_REG = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              int_ack,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic              hblank,
  output logic              hint_req,
  output logic [7:0]        hcount,
  output logic [8:0]        vcount,
  output logic [15:0]       status,
  output logic              cap_stb,
  output logic              ack_stb,
  output logic              disp_en,
  output logic [7:0]        border,
  output logic [NREG*8-1:0] line_regs
);
  localparam int CW = $clog2(LINE_CYCLES);
  localparam int CAP_DLY = CPU_DIV * CAP_CPU_CYC;
  localparam int ACK_DLY = CPU_DIV * ACK_CPU_CYC;
  localparam logic [CW-1:0] CAP_M1   = CW'(CAP_DLY - 1);
  localparam logic [CW-1:0] ACK_M1   = CW'(ACK_DLY - 1);
  localparam logic [CW-1:0] ACT_N_M1 = CW'(ACT_START_NARROW - 1);
  localparam logic [CW-1:0] ACT_W_M1 = CW'(ACT_START_WIDE - 1);

  logic [CW-1:0] cyc;
  logic          line_end, wide_q;
  logic          blank_q, blank_d, hint_q, hint_d;
  logic          cap_q, cap_d, ack_q, ack_d;
  logic          act_edge;
  logic [NREG*8-1:0] live_flat;

  line_cycle_ctr #(.LINE_CYCLES(LINE_CYCLES), .CW(CW)) u_cyc (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .line_end(line_end));

  hv_counter #(.CW(CW), .LINES(LINES), .VW(9)) u_hv (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .line_end(line_end),
    .wide_in(wide_mode), .hcount(hcount), .vcount(vcount), .wide_q(wide_q));

  line_reg_bank #(.NREG(NREG), .DW(8), .AW(4)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .capture(cap_d), .live_flat(live_flat),
    .line_flat(line_regs));

  assign act_edge = (cyc == (wide_q ? ACT_W_M1 : ACT_N_M1));

  always_comb begin
    blank_d = blank_q;
    if (line_end)      blank_d = 1'b1;
    else if (act_edge) blank_d = 1'b0;
    hint_d = hint_q;
    if (line_end)     hint_d = 1'b1;
    else if (int_ack) hint_d = 1'b0;
    cap_d = (cyc == CAP_M1);
    ack_d = (cyc == ACK_M1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= 1'b0;
      hint_q  <= 1'b0;
      cap_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      blank_q <= blank_d;
      hint_q  <= hint_d;
      cap_q   <= cap_d;
      ack_q   <= ack_d;
    end
  end

  assign hblank   = blank_q;
  assign hint_req = hint_q;
  assign cap_stb  = cap_q;
  assign ack_stb  = ack_q;
  assign disp_en  = live_flat[CTRL_REG*8 + DISP_BIT];
  assign border   = live_flat[BORDER_REG*8 +: 8];

  always_comb begin
    status = '0;
    status[STAT_BLANK_BIT] = blank_q;
    status[STAT_HINT_BIT]  = hint_q;
  end

  // R2
  line_start_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hblank && hint_req && (cyc == '0)));

  // R5
  blank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_edge && !line_end) |=> !hblank);

  // R9
  strobe_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> !ack_stb);

  // R10
  hint_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hint_req && !int_ack) |=> hint_req);

  // R10
  hint_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !line_end) |=> !hint_req);
endmodule

// File: tb/scanline_timer_test.sv
module scanline_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_mode = 1'b0, int_ack = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic hblank, hint_req, cap_stb, ack_stb, disp_en;
  logic [7:0] hcount, border;
  logic [8:0] vcount;
  logic [15:0] status;
  logic [127:0] line_regs;

  int checks = 0, failures = 0, edges = 0;
  bit done = 0;

  always #10 clk = ~clk;

  scanline_timer #(.LINES(4)) uut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .int_ack(int_ack),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hblank(hblank), .hint_req(hint_req), .hcount(hcount), .vcount(vcount),
    .status(status), .cap_stb(cap_stb), .ack_stb(ack_stb),
    .disp_en(disp_en), .border(border), .line_regs(line_regs));

  // {edge count, hblank, hcount, vcount, cap_stb, ack_stb}, narrow mode
  localparam logic [35:0] VEC [9] = '{
    {16'd0,    1'b0, 8'd0,   9'd0, 1'b0, 1'b0},
    {16'd252,  1'b0, 8'd31,  9'd0, 1'b1, 1'b0},
    {16'd308,  1'b0, 8'd38,  9'd0, 1'b0, 1'b1},
    {16'd3415, 1'b0, 8'd170, 9'd0, 1'b0, 1'b0},
    {16'd3416, 1'b1, 8'd133, 9'd1, 1'b0, 1'b0},
    {16'd3424, 1'b1, 8'd134, 9'd1, 1'b0, 1'b0},
    {16'd3668, 1'b1, 8'd164, 9'd1, 1'b1, 1'b0},
    {16'd5975, 1'b1, 8'd196, 9'd1, 1'b0, 1'b0},
    {16'd5976, 1'b0, 8'd197, 9'd1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step_to(input int k);
    while (edges < k) begin
      @(posedge clk);
      edges++;
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step_to(edges + 1);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 hblank in reset", hblank, 0);
    chk("R12 hint in reset", hint_req, 0);
    chk("R12 status in reset", status, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      if (VEC[i][35:20] != 0) step_to(int'(VEC[i][35:20]));
      chk("R5 R12 hblank", hblank, VEC[i][19]);
      chk("R4 R3 hcount", hcount, VEC[i][18:11]);
      chk("R2 vcount", vcount, VEC[i][10:2]);
      chk("R7 cap_stb", cap_stb, VEC[i][1]);
      chk("R9 ack_stb", ack_stb, VEC[i][0]);
      if (i < 4) chk("R12 no hint in first line", hint_req, 0);
      if (i == 4) chk("R2 hint at line start", hint_req, 1);
      if (i == 4) chk("R6 status blank+hint", status, 16'h0084);
    end

    // R10 request held, then acknowledged
    chk("R10 hint held", hint_req, 1);
    chk("R6 status hint only", status, 16'h0080);
    int_ack = 1'b1;
    step_to(5977);
    int_ack = 1'b0;
    chk("R10 hint cleared", hint_req, 0);
    chk("R6 status clear", status, 0);

    // R3 mode change mid-line has no effect until boundary
    wide_mode = 1'b1;
    step_to(6000);
    chk("R3 mid-line mode ignored", hcount, 200);
    step_to(6832);
    chk("R3 wide restart", hcount, 8'hA5);
    chk("R2 vcount step", vcount, 2);
    chk("R2 hblank set", hblank, 1);

    // R8 immediate registers, R7 per-line copy
    step_to(6932);
    wr(4'd1, 8'h40);
    wr(4'd7, 8'h2C);
    wr(4'd3, 8'h5A);
    chk("R8 disp_en immediate", disp_en, 1);
    chk("R8 border immediate", border, 8'h2C);
    chk("R7 not yet captured", line_regs[31:24], 0);
    step_to(7084);
    chk("R7 cap_stb line2", cap_stb, 1);
    chk("R7 captured", line_regs[31:24], 8'h5A);
    chk("R7 border copy", line_regs[63:56], 8'h2C);
    step_to(7090);
    wr(4'd3, 8'h77);
    step_to(7600);
    chk("R7 late write held off", line_regs[31:24], 8'h5A);
    wr(4'd1, 8'h00);
    chk("R8 disp_en off immediate", disp_en, 0);
    step_to(10248);
    chk("R11 vcount 3", vcount, 3);
    chk("R7 still old before capture", line_regs[31:24], 8'h5A);
    step_to(10500);
    chk("R7 next-line capture", line_regs[31:24], 8'h77);
    step_to(10556);
    chk("R9 ack_stb at 308", ack_stb, 1);
    chk("R9 cap_stb low at 308", cap_stb, 0);
    chk("R10 hint pending again", hint_req, 1);

    // R11 wrap, R10 pending request unaffected by boundary
    step_to(13663);
    chk("R1 last cycle hcount", hcount, (8'hA5 + 426) % 256);
    step_to(13664);
    chk("R11 vcount wrap", vcount, 0);
    chk("R1 R2 hblank new line", hblank, 1);
    chk("R10 hint stays", hint_req, 1);
    chk("R3 wide held", hcount, 8'hA5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule